// File: doc/BRIEF.md
# Bridge I/O Window Address Decoder

This block decides whether a cycle seen on the primary bus is passed on to a secondary card slot. It holds two programmable I/O address windows, a global I/O enable and a legacy-display pass-through control. Each window has a 32-bit start register and a 32-bit end register. Each window also has its own choice between 16-bit and 32-bit address decode.

Software programs the registers one byte at a time through a simple configuration port. Writes take effect on the clock edge. Reads are combinational.

For each cycle that arrives with a valid strobe, the block compares the address and the cycle type against the programmed state. One clock later it raises a registered forward indication.

Top module: `io_win_decoder`

## Requirements
- R1: After reset, every register byte reads zero except window 1 start, whose bytes at offsets 19h, 1Ah and 1Bh read F0h, FFh and FFh. The forward output is low.
- R2: Registers are byte addressed, with multi-byte registers stored little-endian.
  - Offset 00h bit 0 is the global I/O enable.
  - Offset 01h bit 0 is the display pass-through enable.
  - Window w start occupies 10h+8w to 13h+8w.
  - Window w end occupies 14h+8w to 17h+8w.
- R3: Bit 1 of each start register and bits 1:0 of each end register ignore writes and read as zero. Bit 0 of the start register stays writable.
- R4: An I/O cycle hits a window when start ≤ address ≤ end, with the start's low two bits taken as 00 and the end's low two bits taken as 11. Both bounds are inclusive, at 4-byte granularity.
- R5: Start-register bit 0 selects the decode mode. When it is 0, a hit also requires address bits 31:16 to be zero. When it is 1, all 32 bits are compared.
- R6: While the global I/O enable is clear, neither window hits.
- R7: A window whose end lies below its start never hits.
- R8: With the display pass-through enable set, memory cycles in 000A0000h–000BFFFFh are forwarded. This holds regardless of the window settings and the I/O enable.
- R9: With the display pass-through enable set, I/O cycles in 3B0h–3BBh and 3C0h–3DFh are forwarded. These compares are on all 32 address bits. Addresses 3BCh–3BFh are not forwarded.
- R10: Memory cycles are never matched against the I/O windows.
- R11: The forward output is high in the cycle after a valid strobe whose cycle hits a window or a display range. In every other cycle it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrData | input | 8 | Configuration write byte |
| cfgRdData | output | 8 | Configuration read byte at cfgAddr |
| cycValid | input | 1 | Primary cycle valid strobe |
| cycIsIo | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cycAddr | input | 32 | Primary cycle address |
| fwd | output | 1 | Registered forward indication |

## Verification
Addresses are driven one below, exactly at, and one above each window bound and each display range bound. This tells inclusive compares apart from exclusive ones, and shows whether the low end bits are correctly treated as ones.

The same address is sent as an I/O cycle and as a memory cycle, and with the I/O enable on and off. This separates the type gating from the enable gating.

One address whose upper half is non-zero is tried under both decode modes. An end register is then reprogrammed below its start to cover the empty case. Idle cycles placed after hits show that the output drops when no strobe is present.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W    = 32;
  localparam int NUM_WIN   = 2;
  localparam int REG_BYTES = ADDR_W / 8;
  localparam int OFF_CMD   = 'h00;
  localparam int OFF_BRG   = 'h01;
  localparam int OFF_WIN   = 'h10;
  localparam int WIN_STRIDE = 2 * REG_BYTES;

  // reset value of each window start register
  localparam logic [NUM_WIN-1:0][ADDR_W-1:0] BASE_RST = {32'hFFFF_F000, 32'h0000_0000};

  typedef struct packed {
    logic                                 cmdWr;
    logic                                 brgWr;
    logic [NUM_WIN-1:0][REG_BYTES-1:0]    baseWr;
    logic [NUM_WIN-1:0][REG_BYTES-1:0]    limWr;
  } cfgWrStrb_t;

  typedef struct packed {
    logic                                 cmdRd;
    logic                                 brgRd;
    logic [NUM_WIN-1:0][REG_BYTES-1:0]    baseRd;
    logic [NUM_WIN-1:0][REG_BYTES-1:0]    limRd;
  } cfgRdSel_t;
endpackage

// File: rtl/bwd_ctrl.sv
module bwd_ctrl
  import bwd_pkg::*;
#(
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  output cfgWrStrb_t        wrStrb,
  output cfgRdSel_t         rdSel
);
  always_comb begin
    rdSel = '0;
    rdSel.cmdRd = (cfgAddr == CFG_AW'(OFF_CMD));
    rdSel.brgRd = (cfgAddr == CFG_AW'(OFF_BRG));
    for (int w = 0; w < NUM_WIN; w++) begin
      for (int b = 0; b < REG_BYTES; b++) begin
        rdSel.baseRd[w][b] = (cfgAddr == CFG_AW'(OFF_WIN + w * WIN_STRIDE + b));
        rdSel.limRd[w][b]  = (cfgAddr == CFG_AW'(OFF_WIN + w * WIN_STRIDE + REG_BYTES + b));
      end
    end
  end

  always_comb begin
    wrStrb = cfgWrEn ? cfgWrStrb_t'(rdSel) : '0;
  end

  // R2: at most one register byte selected per write
  p_one_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStrb));
endmodule

// File: rtl/bwd_window.sv
module bwd_window
  import bwd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              isIo,
  input  logic              ioEn,
  input  logic [ADDR_W-1:0] startReg,
  input  logic [ADDR_W-1:0] endReg,
  output logic              hit
);
  logic [ADDR_W-1:0] loBound;
  logic [ADDR_W-1:0] hiBound;
  logic              upperOk;

  assign loBound = {startReg[ADDR_W-1:2], 2'b00};
  assign hiBound = {endReg[ADDR_W-1:2], 2'b11};
  // start bit 0 = full decode; else upper half must be zero
  assign upperOk = startReg[0] || (addr[ADDR_W-1:16] == '0);
  assign hit = isIo && ioEn && upperOk && (addr >= loBound) && (addr <= hiBound);
endmodule

// File: rtl/bwd_datapath.sv
module bwd_datapath
  import bwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfgWrStrb_t        wrStrb,
  input  cfgRdSel_t         rdSel,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              cycValid,
  input  logic              cycIsIo,
  input  logic [ADDR_W-1:0] cycAddr,
  output logic              fwd
);
  logic                            ioEnQ;
  logic                            vgaQ;
  logic [NUM_WIN-1:0][ADDR_W-1:0]  startQ;
  logic [NUM_WIN-1:0][ADDR_W-1:0]  endQ;
  logic [NUM_WIN-1:0]              winHit;
  logic                            vgaMem;
  logic                            vgaIo;
  logic                            fwdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioEnQ  <= 1'b0;
      vgaQ   <= 1'b0;
      startQ <= BASE_RST;
      endQ   <= '0;
    end else begin
      if (wrStrb.cmdWr) ioEnQ <= cfgWrData[0];
      if (wrStrb.brgWr) vgaQ  <= cfgWrData[0];
      for (int w = 0; w < NUM_WIN; w++) begin
        for (int b = 0; b < REG_BYTES; b++) begin
          if (wrStrb.baseWr[w][b])
            startQ[w][8*b +: 8] <= (b == 0) ? {cfgWrData[7:2], 1'b0, cfgWrData[0]} : cfgWrData;
          if (wrStrb.limWr[w][b])
            endQ[w][8*b +: 8] <= (b == 0) ? {cfgWrData[7:2], 2'b00} : cfgWrData;
        end
      end
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (rdSel.cmdRd) cfgRdData = {7'b0, ioEnQ};
    if (rdSel.brgRd) cfgRdData = {7'b0, vgaQ};
    for (int w = 0; w < NUM_WIN; w++) begin
      for (int b = 0; b < REG_BYTES; b++) begin
        if (rdSel.baseRd[w][b]) cfgRdData = startQ[w][8*b +: 8];
        if (rdSel.limRd[w][b])  cfgRdData = endQ[w][8*b +: 8];
      end
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    bwd_window u_win (
      .addr     (cycAddr),
      .isIo     (cycIsIo),
      .ioEn     (ioEnQ),
      .startReg (startQ[g]),
      .endReg   (endQ[g]),
      .hit      (winHit[g])
    );

    // R7: an inverted window never matches
    p_empty_win_r7: assert property (@(posedge clk) disable iff (!rstN)
      winHit[g] |-> (startQ[g][ADDR_W-1:2] <= endQ[g][ADDR_W-1:2]));
    // R5: 16-bit decode only matches low 64K
    p_mode16_r5: assert property (@(posedge clk) disable iff (!rstN)
      (winHit[g] && !startQ[g][0]) |-> (cycAddr[ADDR_W-1:16] == '0));
  end

  assign vgaMem = !cycIsIo && (cycAddr >= 32'h000A_0000) && (cycAddr <= 32'h000B_FFFF);
  assign vgaIo  = cycIsIo && (((cycAddr >= 32'h3B0) && (cycAddr <= 32'h3BB)) ||
                              ((cycAddr >= 32'h3C0) && (cycAddr <= 32'h3DF)));

  always_ff @(posedge clk) begin
    if (!rstN) fwdQ <= 1'b0;
    else       fwdQ <= cycValid && ((|winHit) || (vgaQ && (vgaMem || vgaIo)));
  end
  assign fwd = fwdQ;

  // R6: windows silent while the I/O enable is off
  p_io_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ioEnQ |-> (winHit == '0));
  // R10: memory cycles never hit a window
  p_mem_no_win_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cycIsIo |-> (winHit == '0));
  // R11: no strobe, no forward next cycle
  p_idle_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !cycValid |=> !fwd);
endmodule

// File: rtl/io_win_decoder.sv
module io_win_decoder
  import bwd_pkg::*;
#(
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              cycValid,
  input  logic              cycIsIo,
  input  logic [ADDR_W-1:0] cycAddr,
  output logic              fwd
);
  cfgWrStrb_t wrStrb;
  cfgRdSel_t  rdSel;

  bwd_ctrl #(.CFG_AW(CFG_AW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .wrStrb  (wrStrb),
    .rdSel   (rdSel)
  );

  bwd_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrStrb    (wrStrb),
    .rdSel     (rdSel),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .cycValid  (cycValid),
    .cycIsIo   (cycIsIo),
    .cycAddr   (cycAddr),
    .fwd       (fwd)
  );
endmodule

// File: tb/io_win_decoder_tb_top.sv
module io_win_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        cycValid = 1'b0;
  logic        cycIsIo = 1'b0;
  logic [31:0] cycAddr = '0;
  logic        fwd;

  int total = 0;
  int bad = 0;
  int cycCnt = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic        exp;
    string       req;
    logic [31:0] addr;
  } item_t;
  item_t sbQ[$];

  io_win_decoder dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .cycValid(cycValid),
    .cycIsIo(cycIsIo), .cycAddr(cycAddr), .fwd(fwd)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [7:0] a, input logic [7:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRd(input logic [7:0] a, input logic [7:0] exp, input string req);
    cfgAddr = a;
    #1;
    check({24'b0, cfgRdData}, {24'b0, exp}, req, $sformatf("read %0h", a));
  endtask

  // driver: one cycle, expected result queued for the monitor
  task automatic sendCyc(input logic [31:0] a, input logic io, input logic e, input string req);
    item_t it;
    cycValid = 1'b1; cycAddr = a; cycIsIo = io;
    it.due = cycCnt + 1; it.exp = e; it.req = req; it.addr = a;
    sbQ.push_back(it);
    @(negedge clk);
    cycValid = 1'b0;
  endtask

  task automatic idleCyc(input string req);
    item_t it;
    cycValid = 1'b0;
    it.due = cycCnt + 1; it.exp = 1'b0; it.req = req; it.addr = '0;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbQ.size() > 0 && sbQ[0].due == cycCnt) begin
        item_t it;
        it = sbQ.pop_front();
        check({31'b0, fwd}, {31'b0, it.exp}, it.req, $sformatf("fwd for addr %0h", it.addr));
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({31'b0, fwd}, 32'd0, "R1", "fwd in reset");
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    cfgRd(8'h18, 8'h00, "R1");
    cfgRd(8'h19, 8'hF0, "R1");
    cfgRd(8'h1A, 8'hFF, "R1");
    cfgRd(8'h1B, 8'hFF, "R1");
    cfgRd(8'h11, 8'h00, "R1");
    cfgRd(8'h14, 8'h00, "R1");
    cfgRd(8'h00, 8'h00, "R1");
    check({31'b0, fwd}, 32'd0, "R1", "fwd after reset");

    // window 0: 0x1000..0x10FF, 16-bit decode
    cfgWr(8'h10, 8'h00); cfgWr(8'h11, 8'h10);
    cfgWr(8'h14, 8'hFF); cfgWr(8'h15, 8'h10);
    cfgRd(8'h14, 8'hFC, "R3");
    cfgRd(8'h11, 8'h10, "R2");
    sendCyc(32'h1000, 1'b1, 1'b0, "R6");
    cfgWr(8'h00, 8'h01);
    sendCyc(32'h1000, 1'b1, 1'b1, "R4");
    idleCyc("R11");
    sendCyc(32'h0FFF, 1'b1, 1'b0, "R4");
    sendCyc(32'h10FF, 1'b1, 1'b1, "R4");
    sendCyc(32'h1100, 1'b1, 1'b0, "R4");
    sendCyc(32'h1000, 1'b0, 1'b0, "R10");

    // window 1: 0x10000..0x1FFFF
    cfgWr(8'h18, 8'h00); cfgWr(8'h19, 8'h00); cfgWr(8'h1A, 8'h01); cfgWr(8'h1B, 8'h00);
    cfgWr(8'h1C, 8'hFF); cfgWr(8'h1D, 8'hFF); cfgWr(8'h1E, 8'h01); cfgWr(8'h1F, 8'h00);
    cfgRd(8'h1A, 8'h01, "R2");
    cfgRd(8'h1E, 8'h01, "R2");
    sendCyc(32'h0001_0010, 1'b1, 1'b0, "R5");
    cfgWr(8'h18, 8'h03);
    cfgRd(8'h18, 8'h01, "R3");
    sendCyc(32'h0001_0010, 1'b1, 1'b1, "R5");
    sendCyc(32'h0001_0010, 1'b0, 1'b0, "R10");

    // window 0 end below start
    cfgWr(8'h14, 8'hFF); cfgWr(8'h15, 8'h0F);
    sendCyc(32'h1000, 1'b1, 1'b0, "R7");
    sendCyc(32'h0FFC, 1'b1, 1'b0, "R7");

    // display pass-through
    sendCyc(32'h000A_0000, 1'b0, 1'b0, "R8");
    cfgWr(8'h01, 8'h01);
    cfgRd(8'h01, 8'h01, "R2");
    cfgWr(8'h00, 8'h00);
    sendCyc(32'h000A_0000, 1'b0, 1'b1, "R8");
    idleCyc("R11");
    sendCyc(32'h000B_FFFF, 1'b0, 1'b1, "R8");
    sendCyc(32'h0009_FFFF, 1'b0, 1'b0, "R8");
    sendCyc(32'h000C_0000, 1'b0, 1'b0, "R8");
    sendCyc(32'h000A_0000, 1'b1, 1'b0, "R8");
    sendCyc(32'h3B0, 1'b1, 1'b1, "R9");
    sendCyc(32'h3BB, 1'b1, 1'b1, "R9");
    sendCyc(32'h3BC, 1'b1, 1'b0, "R9");
    sendCyc(32'h3C0, 1'b1, 1'b1, "R9");
    sendCyc(32'h3DF, 1'b1, 1'b1, "R9");
    sendCyc(32'h3E0, 1'b1, 1'b0, "R9");
    sendCyc(32'h0001_03C0, 1'b1, 1'b0, "R9");
    sendCyc(32'h3C0, 1'b0, 1'b0, "R9");
    idleCyc("R11");

    repeat (3) @(negedge clk);
    check(sbQ.size(), 32'd0, "R11", "scoreboard drained");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule